// File: doc/BRIEF.md
# OTP Fuse Read Sequencer

This block reads a contiguous run of bytes out of a one-time-programmable fuse array. A requester presents a start address and a byte count for one cycle while the block is idle. The block then brings the array up in a fixed order. It raises a write-mask override, then the first power enable, and waits a settling time. It then raises the second power enable and releases the isolation between the array and the core logic.

Once the array is open, the block handles each address in turn. It issues a one-cycle read start with the address on the array address bus. This clears the array's ready flag. The block then polls that flag at a fixed interval, up to a limit of attempts. When ready is seen, the low data byte from the array is captured and delivered as a one-cycle byte strobe. After the last byte, or after a poll that runs out of attempts, the block closes the array in reverse order and pulses `done` as it returns to idle. A timeout leaves an error flag standing until the next accepted request. A zero-length request finishes at once and never touches the array.

Top module: `fuse_rd_seq`

## Requirements
- R1: While reset is held and right after it, all enables and the override are low, isolation (`fuseIsoEn`) is high, and `busy`, `fuseRdStart`, `byteValid`, `done` and `errTimeout` are low.
- R2: A non-empty request raises `fuseWrMaskOvr`, then `fusePwrEnA` one cycle later, waits SETTLE_CYC cycles, raises `fusePwrEnB`, and drops `fuseIsoEn` in the following cycle.
- R3: Each read begins with `fuseRdStart` high for exactly one cycle. During that cycle `fuseAddr` shows the address, and isolation is already released.
- R4: When ready is sampled high, `byteValid` is high in the next cycle for exactly one cycle, and `byteData` holds the array data from the sampling cycle.
- R5: The addresses read are the start address, then that address plus 1, and so on, wrapping modulo 2^ADDR_W. Exactly the requested count of bytes is produced when no timeout occurs.
- R6: Ready is sampled once every POLL_GAP_CYC cycles. If POLL_LIMIT samples in a row see it low, `errTimeout` goes high, and no further read start or byte follows.
- R7: Power-down, after the last byte or an abort, raises isolation, then drops `fusePwrEnB`, waits SETTLE_CYC cycles, drops `fusePwrEnA`, then drops `fuseWrMaskOvr`, one step per cycle apart from the wait.
- R8: `done` is a one-cycle pulse that appears in the first cycle with `busy` low after a request.
- R9: A request with count 0 gives `busy` for one cycle and then `done`. No enable, isolation or read start changes.
- R10: `reqValid` has no effect while `busy` is high.
- R11: `errTimeout` stays high after an abort until the next request is accepted, and is cleared then.
- R12: The first ready sample of each read falls POLL_GAP_CYC cycles after the read start. A ready that rises earlier is not taken before that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken only while idle |
| reqAddr | input | ADDR_W | First fuse address to read |
| reqLen | input | ADDR_W+1 | Number of bytes to read |
| busy | output | 1 | High from request acceptance until return to idle |
| fuseWrMaskOvr | output | 1 | Write-mask override for the power controls |
| fusePwrEnA | output | 1 | First array power enable |
| fusePwrEnB | output | 1 | Second array power enable |
| fuseIsoEn | output | 1 | Isolation between array and core, high means isolated |
| fuseAddr | output | ADDR_W | Array read address |
| fuseRdStart | output | 1 | One-cycle read start that also clears array ready |
| fuseRdy | input | 1 | Array ready flag |
| fuseData | input | 8 | Low byte of the array control word |
| byteValid | output | 1 | One-cycle strobe for a captured byte |
| byteData | output | 8 | Captured byte |
| done | output | 1 | One-cycle completion pulse |
| errTimeout | output | 1 | Poll timeout flag, held until the next request |

## Verification
The bench builds the block with SETTLE_CYC = 6, POLL_GAP_CYC = 3 and POLL_LIMIT = 4. With these values a full power-up, read and power-down takes a few dozen cycles instead of a second. It also lets a responder latency of 13 cycles run past the timeout after exactly four failed samples. With a poll gap of 3, a ready that rises in the second poll cycle shows whether the design waits for its own sample point. A start address of 0x7FE with the 11-bit address default checks wrap-around. A request raised in the middle of the settle wait checks that the block stays on its course.

// File: rtl/fuse_seq_pkg.sv
`timescale 1ns/1ps
package fuse_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UP_MASK,
    ST_UP_PWRA,
    ST_UP_WAIT,
    ST_UP_PWRB,
    ST_UP_OPEN,
    ST_RD_ISSUE,
    ST_RD_POLL,
    ST_DN_ISO,
    ST_DN_PWRB,
    ST_DN_WAIT,
    ST_DN_PWRA,
    ST_DN_MASK,
    ST_FIN
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic setMask;
    logic clrMask;
    logic setPwrA;
    logic clrPwrA;
    logic setPwrB;
    logic clrPwrB;
    logic setIso;
    logic clrIso;
    logic loadDelay;
    logic tickDelay;
    logic issue;
    logic tickGap;
    logic retry;
    logic capture;
    logic abort;
    logic finish;
  } seqCmd_t;

  // flags from datapath to control
  typedef struct packed {
    logic reqLenZero;
    logic delayDone;
    logic gapDone;
    logic triesOut;
    logic lastByte;
  } seqStat_t;

endpackage

// File: rtl/fuse_seq_ctrl.sv
`timescale 1ns/1ps
module fuse_seq_ctrl
  import fuse_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reqValid,
  input  logic     fuseRdy,
  input  seqStat_t stat,
  output seqCmd_t  cmd,
  output logic     busy
);

  seqState_e state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    cmd       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          cmd.loadReq = 1'b1;
          stateNext   = stat.reqLenZero ? ST_FIN : ST_UP_MASK;
        end
      end
      ST_UP_MASK: begin
        cmd.setMask = 1'b1;
        stateNext   = ST_UP_PWRA;
      end
      ST_UP_PWRA: begin
        cmd.setPwrA   = 1'b1;
        cmd.loadDelay = 1'b1;
        stateNext     = ST_UP_WAIT;
      end
      ST_UP_WAIT: begin
        if (stat.delayDone) stateNext = ST_UP_PWRB;
        else                cmd.tickDelay = 1'b1;
      end
      ST_UP_PWRB: begin
        cmd.setPwrB = 1'b1;
        stateNext   = ST_UP_OPEN;
      end
      ST_UP_OPEN: begin
        cmd.clrIso = 1'b1;
        stateNext  = ST_RD_ISSUE;
      end
      ST_RD_ISSUE: begin
        cmd.issue = 1'b1;
        stateNext = ST_RD_POLL;
      end
      ST_RD_POLL: begin
        if (!stat.gapDone) begin
          cmd.tickGap = 1'b1;
        end else if (fuseRdy) begin
          cmd.capture = 1'b1;
          stateNext   = stat.lastByte ? ST_DN_ISO : ST_RD_ISSUE;
        end else if (stat.triesOut) begin
          cmd.abort = 1'b1;
          stateNext = ST_DN_ISO;
        end else begin
          cmd.retry = 1'b1;
        end
      end
      ST_DN_ISO: begin
        cmd.setIso = 1'b1;
        stateNext  = ST_DN_PWRB;
      end
      ST_DN_PWRB: begin
        cmd.clrPwrB   = 1'b1;
        cmd.loadDelay = 1'b1;
        stateNext     = ST_DN_WAIT;
      end
      ST_DN_WAIT: begin
        if (stat.delayDone) stateNext = ST_DN_PWRA;
        else                cmd.tickDelay = 1'b1;
      end
      ST_DN_PWRA: begin
        cmd.clrPwrA = 1'b1;
        stateNext   = ST_DN_MASK;
      end
      ST_DN_MASK: begin
        cmd.clrMask = 1'b1;
        stateNext   = ST_FIN;
      end
      ST_FIN: begin
        cmd.finish = 1'b1;
        stateNext  = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/fuse_seq_dp.sv
`timescale 1ns/1ps
module fuse_seq_dp
  import fuse_seq_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int LEN_W        = ADDR_W + 1,
  parameter int SETTLE_CYC   = 125000,
  parameter int POLL_GAP_CYC = 125,
  parameter int POLL_LIMIT   = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqCmd_t           cmd,
  output seqStat_t          stat,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [7:0]        fuseData,
  output logic              fuseWrMaskOvr,
  output logic              fusePwrEnA,
  output logic              fusePwrEnB,
  output logic              fuseIsoEn,
  output logic [ADDR_W-1:0] fuseAddr,
  output logic              fuseRdStart,
  output logic              byteValid,
  output logic [7:0]        byteData,
  output logic              done,
  output logic              errTimeout
);

  localparam int DLY_W = $clog2(SETTLE_CYC + 1);
  localparam int TRY_W = $clog2(POLL_LIMIT + 1);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(SETTLE_CYC - 1);
  localparam logic [TRY_W-1:0] TRY_LOAD = TRY_W'(POLL_LIMIT - 1);

  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remain;
  logic [DLY_W-1:0]  dlyCnt;
  logic [TRY_W-1:0]  triesLeft;
  logic              gapDoneW;

  // power and isolation controls
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fuseWrMaskOvr <= 1'b0;
      fusePwrEnA    <= 1'b0;
      fusePwrEnB    <= 1'b0;
      fuseIsoEn     <= 1'b1;
    end else begin
      if (cmd.setMask)      fuseWrMaskOvr <= 1'b1;
      else if (cmd.clrMask) fuseWrMaskOvr <= 1'b0;
      if (cmd.setPwrA)      fusePwrEnA <= 1'b1;
      else if (cmd.clrPwrA) fusePwrEnA <= 1'b0;
      if (cmd.setPwrB)      fusePwrEnB <= 1'b1;
      else if (cmd.clrPwrB) fusePwrEnB <= 1'b0;
      if (cmd.setIso)       fuseIsoEn <= 1'b1;
      else if (cmd.clrIso)  fuseIsoEn <= 1'b0;
    end
  end

  // address and remaining count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curAddr <= '0;
      remain  <= '0;
    end else if (cmd.loadReq) begin
      curAddr <= reqAddr;
      remain  <= reqLen;
    end else if (cmd.capture) begin
      curAddr <= curAddr + 1'b1;
      remain  <= remain - 1'b1;
    end
  end

  // settle delay
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             dlyCnt <= '0;
    else if (cmd.loadDelay) dlyCnt <= DLY_LOAD;
    else if (cmd.tickDelay) dlyCnt <= dlyCnt - 1'b1;
  end

  // poll attempt budget
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         triesLeft <= '0;
    else if (cmd.issue) triesLeft <= TRY_LOAD;
    else if (cmd.retry) triesLeft <= triesLeft - 1'b1;
  end

  // poll interval: a counter only when the interval exceeds one cycle
  generate
    if (POLL_GAP_CYC > 1) begin : g_gapCnt
      localparam int GAP_W = $clog2(POLL_GAP_CYC + 1);
      localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(POLL_GAP_CYC - 1);
      logic [GAP_W-1:0] gapCnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     gapCnt <= '0;
        else if (cmd.issue | cmd.retry) gapCnt <= GAP_LOAD;
        else if (cmd.tickGap)           gapCnt <= gapCnt - 1'b1;
      end
      assign gapDoneW = (gapCnt == '0);
    end else begin : g_gapNone
      assign gapDoneW = 1'b1;
    end
  endgenerate

  // byte output, completion and error
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byteValid  <= 1'b0;
      byteData   <= '0;
      done       <= 1'b0;
      errTimeout <= 1'b0;
    end else begin
      byteValid <= cmd.capture;
      if (cmd.capture) byteData <= fuseData;
      done <= cmd.finish;
      if (cmd.loadReq)    errTimeout <= 1'b0;
      else if (cmd.abort) errTimeout <= 1'b1;
    end
  end

  assign fuseAddr    = curAddr;
  assign fuseRdStart = cmd.issue;

  assign stat.reqLenZero = (reqLen == '0);
  assign stat.delayDone  = (dlyCnt == '0);
  assign stat.gapDone    = gapDoneW;
  assign stat.triesOut   = (triesLeft == '0);
  assign stat.lastByte   = (remain == LEN_W'(1));

endmodule

// File: rtl/fuse_rd_seq.sv
`timescale 1ns/1ps
module fuse_rd_seq
  import fuse_seq_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int SETTLE_CYC   = 125000,
  parameter int POLL_GAP_CYC = 125,
  parameter int POLL_LIMIT   = 1000000,
  localparam int LEN_W       = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              busy,
  output logic              fuseWrMaskOvr,
  output logic              fusePwrEnA,
  output logic              fusePwrEnB,
  output logic              fuseIsoEn,
  output logic [ADDR_W-1:0] fuseAddr,
  output logic              fuseRdStart,
  input  logic              fuseRdy,
  input  logic [7:0]        fuseData,
  output logic              byteValid,
  output logic [7:0]        byteData,
  output logic              done,
  output logic              errTimeout
);

  seqCmd_t  seqCmd;
  seqStat_t seqStat;

  fuse_seq_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .fuseRdy  (fuseRdy),
    .stat     (seqStat),
    .cmd      (seqCmd),
    .busy     (busy)
  );

  fuse_seq_dp #(
    .ADDR_W       (ADDR_W),
    .LEN_W        (LEN_W),
    .SETTLE_CYC   (SETTLE_CYC),
    .POLL_GAP_CYC (POLL_GAP_CYC),
    .POLL_LIMIT   (POLL_LIMIT)
  ) dp_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd           (seqCmd),
    .stat          (seqStat),
    .reqAddr       (reqAddr),
    .reqLen        (reqLen),
    .fuseData      (fuseData),
    .fuseWrMaskOvr (fuseWrMaskOvr),
    .fusePwrEnA    (fusePwrEnA),
    .fusePwrEnB    (fusePwrEnB),
    .fuseIsoEn     (fuseIsoEn),
    .fuseAddr      (fuseAddr),
    .fuseRdStart   (fuseRdStart),
    .byteValid     (byteValid),
    .byteData      (byteData),
    .done          (done),
    .errTimeout    (errTimeout)
  );

endmodule

// File: rtl/fuse_rd_seq_chk.sv
`timescale 1ns/1ps
module fuse_rd_seq_chk #(
  parameter int SETTLE_CYC = 125000
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic fuseWrMaskOvr,
  input logic fusePwrEnA,
  input logic fusePwrEnB,
  input logic fuseIsoEn,
  input logic fuseRdStart,
  input logic fuseRdy,
  input logic byteValid,
  input logic done,
  input logic errTimeout
);

  localparam int SC_W = $clog2(SETTLE_CYC + 2) + 1;
  localparam logic [SC_W-1:0] SC_MAX = '1;

  // cycles spent with only the first power enable on
  logic [SC_W-1:0] soloCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        soloCnt <= '0;
    else if (!fusePwrEnA || fusePwrEnB) soloCnt <= '0;
    else if (soloCnt != SC_MAX)         soloCnt <= soloCnt + 1'b1;
  end

  AST_PWRB_NEEDS_PWRA: assert property (@(posedge clk) disable iff (!rst_n)
    fusePwrEnB |-> fusePwrEnA);  // R2
  AST_OPEN_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    !fuseIsoEn |-> (fusePwrEnB && fuseWrMaskOvr));  // R2
  AST_SETTLE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fusePwrEnB) |-> (soloCnt >= SC_W'(SETTLE_CYC)));  // R2
  AST_START_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    fuseRdStart |-> !fuseIsoEn);  // R3
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fuseRdStart |=> !fuseRdStart);  // R3
  AST_BYTE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    byteValid |-> $past(fuseRdy));  // R4
  AST_NO_BYTE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    errTimeout |-> !byteValid);  // R6
  AST_ISO_BEFORE_PWRB_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fusePwrEnB) |-> fuseIsoEn);  // R7
  AST_SETTLE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fusePwrEnA) |-> (soloCnt >= SC_W'(SETTLE_CYC)));  // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R8

endmodule

bind fuse_rd_seq fuse_rd_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .fuseWrMaskOvr (fuseWrMaskOvr),
  .fusePwrEnA    (fusePwrEnA),
  .fusePwrEnB    (fusePwrEnB),
  .fuseIsoEn     (fuseIsoEn),
  .fuseRdStart   (fuseRdStart),
  .fuseRdy       (fuseRdy),
  .byteValid     (byteValid),
  .done          (done),
  .errTimeout    (errTimeout)
);

// File: tb/fuse_rd_seq_tb_top.sv
`timescale 1ns/1ps
module fuse_rd_seq_tb_top;

  localparam int AW     = 11;
  localparam int LW     = AW + 1;
  localparam int SETTLE = 6;
  localparam int GAP    = 3;
  localparam int LIMIT  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          reqValid;
  logic [AW-1:0] reqAddr;
  logic [LW-1:0] reqLen;
  logic          busy, fuseWrMaskOvr, fusePwrEnA, fusePwrEnB, fuseIsoEn;
  logic [AW-1:0] fuseAddr;
  logic          fuseRdStart;
  logic          fuseRdy;
  logic [7:0]    fuseData;
  logic          byteValid;
  logic [7:0]    byteData;
  logic          done, errTimeout;

  fuse_rd_seq #(
    .ADDR_W       (AW),
    .SETTLE_CYC   (SETTLE),
    .POLL_GAP_CYC (GAP),
    .POLL_LIMIT   (LIMIT)
  ) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .reqValid      (reqValid),
    .reqAddr       (reqAddr),
    .reqLen        (reqLen),
    .busy          (busy),
    .fuseWrMaskOvr (fuseWrMaskOvr),
    .fusePwrEnA    (fusePwrEnA),
    .fusePwrEnB    (fusePwrEnB),
    .fuseIsoEn     (fuseIsoEn),
    .fuseAddr      (fuseAddr),
    .fuseRdStart   (fuseRdStart),
    .fuseRdy       (fuseRdy),
    .fuseData      (fuseData),
    .byteValid     (byteValid),
    .byteData      (byteData),
    .done          (done),
    .errTimeout    (errTimeout)
  );

  // array responder, clocked on the falling edge
  logic [AW-1:0] pendAddr;
  int            latCnt;
  int            respLat;

  function automatic logic [7:0] cellVal(input logic [AW-1:0] a);
    logic [15:0] t;
    t = 16'(a) * 16'd7;
    return t[7:0] ^ 8'h5A;
  endfunction

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fuseRdy  <= 1'b0;
      latCnt   <= 0;
      pendAddr <= '0;
    end else if (fuseRdStart) begin
      fuseRdy  <= 1'b0;
      pendAddr <= fuseAddr;
      latCnt   <= respLat;
    end else if (latCnt > 0) begin
      latCnt <= latCnt - 1;
      if (latCnt == 1) fuseRdy <= 1'b1;
    end
  end

  assign fuseData = fuseRdy ? cellVal(pendAddr) : 8'hEE;

  // expected outputs
  logic          eMask, ePwrA, ePwrB, eIso, eBusy, eStart, eByteV, eDone, eErr;
  logic [7:0]    eByteD;
  logic [AW-1:0] eAddr;
  string         railTag, byteTag;
  bit            cmpOn;
  int            vectors, miscompares;

  task automatic chkBit(input string tag, input string nm, input logic act, input logic exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn) begin
      vectors++;
      chkBit(railTag, "fuseWrMaskOvr", fuseWrMaskOvr, eMask);
      chkBit(railTag, "fusePwrEnA", fusePwrEnA, ePwrA);
      chkBit(railTag, "fusePwrEnB", fusePwrEnB, ePwrB);
      chkBit(railTag, "fuseIsoEn", fuseIsoEn, eIso);
      chkBit("R10", "busy", busy, eBusy);
      chkBit("R3", "fuseRdStart", fuseRdStart, eStart);
      if (eStart && fuseAddr !== eAddr) begin
        miscompares++;
        $display("FAIL R5 fuseAddr actual=%h expected=%h at %0t", fuseAddr, eAddr, $time);
      end
      chkBit(byteTag, "byteValid", byteValid, eByteV);
      if (eByteV && byteData !== eByteD) begin
        miscompares++;
        $display("FAIL R4 byteData actual=%h expected=%h at %0t", byteData, eByteD, $time);
      end
      chkBit("R8", "done", done, eDone);
      chkBit("R6", "errTimeout", errTimeout, eErr);
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    eStart   = 1'b0;
    eByteV   = 1'b0;
    eDone    = 1'b0;
  endtask

  // behavioural expectation of one request
  task automatic runReq(input logic [AW-1:0] a, input int n, input int lat,
                        input int abortIdx, input bit poke);
    bit aborted;
    int tries;
    int k;
    logic rdyNow;
    reqAddr  = a;
    reqLen   = LW'(n);
    reqValid = 1'b1;
    railTag  = (n == 0) ? "R9" : "R2";
    tick();
    eBusy = 1'b1;
    eErr  = 1'b0;
    if (n == 0) begin
      tick(); eBusy = 1'b0; eDone = 1'b1;
      tick();
      return;
    end
    tick(); eMask = 1'b1;
    tick(); ePwrA = 1'b1;
    for (int w = 0; w < SETTLE; w++) begin
      tick();
      if (poke && w == 1) begin
        reqValid = 1'b1;   // R10: must be ignored
        reqLen   = '0;
        reqAddr  = 11'h3AB;
      end
    end
    tick(); ePwrB = 1'b1;
    tick(); eIso = 1'b0;
    aborted = 1'b0;
    for (int i = 0; i < n && !aborted; i++) begin
      eStart  = 1'b1;
      eAddr   = a + AW'(i);
      respLat = (i == abortIdx) ? 13 : lat;
      tick();
      tries = 0;
      k = 0;
      forever begin
        k++;
        @(negedge clk);
        #1;
        rdyNow = fuseRdy;
        tick();
        if (k % GAP == 0) begin
          tries++;
          if (rdyNow) begin
            eByteV = 1'b1;
            eByteD = cellVal(a + AW'(i));
            break;
          end else if (tries == LIMIT) begin
            eErr    = 1'b1;
            aborted = 1'b1;
            break;
          end
        end
      end
    end
    railTag = "R7";
    tick(); eIso = 1'b1;
    tick(); ePwrB = 1'b0;
    for (int w = 0; w < SETTLE; w++) tick();
    tick(); ePwrA = 1'b0;
    tick(); eMask = 1'b0;
    tick(); eBusy = 1'b0; eDone = 1'b1;
    tick();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    reqValid = 1'b0; reqAddr = '0; reqLen = '0; respLat = 1;
    eMask = 0; ePwrA = 0; ePwrB = 0; eIso = 1; eBusy = 0; eStart = 0;
    eByteV = 0; eDone = 0; eErr = 0; eByteD = '0; eAddr = '0;
    railTag = "R1"; byteTag = "R4"; cmpOn = 0; vectors = 0; miscompares = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    vectors++;
    chkBit("R1", "fuseWrMaskOvr", fuseWrMaskOvr, 1'b0);
    chkBit("R1", "fusePwrEnA", fusePwrEnA, 1'b0);
    chkBit("R1", "fusePwrEnB", fusePwrEnB, 1'b0);
    chkBit("R1", "fuseIsoEn", fuseIsoEn, 1'b1);
    chkBit("R1", "busy", busy, 1'b0);
    chkBit("R1", "fuseRdStart", fuseRdStart, 1'b0);
    chkBit("R1", "byteValid", byteValid, 1'b0);
    chkBit("R1", "done", done, 1'b0);
    chkBit("R1", "errTimeout", errTimeout, 1'b0);
    rst_n = 1'b1;
    cmpOn = 1'b1;
    repeat (2) tick();

    // R2 R3 R4 R5 R7 R8: plain three-byte read, fast array
    runReq(11'h005, 3, 1, -1, 0);
    // R5 R6: late ready needs a second sample; addresses wrap
    runReq(11'h7FE, 3, 4, -1, 0);
    // R12: ready rises before the first sample point
    byteTag = "R12";
    runReq(11'h100, 2, 2, -1, 0);
    byteTag = "R4";
    // R9: empty request
    runReq(11'h040, 0, 1, -1, 0);
    // R6: third byte times out
    runReq(11'h020, 4, 1, 2, 0);
    // R11: flag holds while idle
    repeat (4) begin
      @(negedge clk);
      vectors++;
      chkBit("R11", "errTimeout held", errTimeout, 1'b1);
    end
    @(posedge clk); #1;
    // R10 R11: request during the settle wait is ignored, flag cleared
    runReq(11'h300, 2, 1, -1, 1);
    // back-to-back empty then full request
    runReq(11'h000, 0, 1, -1, 0);
    runReq(11'h001, 1, 3, -1, 0);
    repeat (3) tick();

    cmpOn = 1'b0;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    summary();
    $finish;
  end

endmodule